// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a serial-port slave that lets a host read and write a bank of thirty-two 8-bit configuration locations, of which twelve are populated. Every cycle opens with an 8-bit command that carries a direction flag, a length code and a 5-bit start address. One to four data bytes follow. All outputs run from one fast system clock, and the serial clock, chip select and data line are sampled as ordinary inputs. Edge detection inside the block finds the serial clock transitions. The block holds no analog function. The current contents of every location are presented on a flat output bus, so that neighbouring logic can decode them.

Location 0x00 configures the port itself. It selects the bit order, selects between a shared bidirectional data line and a separate output pin, and holds a level-sensitive soft reset. The bit order also fixes the address direction for multi-byte transfers. When the most significant bit comes first, the command names the highest location and the address counts down. When the least significant bit comes first, the command names the lowest location and the address counts up. Tri-state pins are modelled as a data output paired with an enable.

Top module: `spi_cfg_slave`

## Requirements
- R1: In MSB-first order the command byte is, from bit 7 down: direction (1 = read, 0 = write), length code in bits 6:5, address in bits 4:0. A written byte is stored once its eighth bit has been sampled.
- R2: When location 0x00 bit 6 is 1, the command and data bits all travel least significant bit first. Reset value 0 gives MSB-first.
- R3: After each data byte the address steps down by one in MSB-first order and up by one in LSB-first order, wrapping modulo 32.
- R4: Length code L moves exactly L+1 data bytes. Further serial clocks before chip select rises are ignored.
- R5: A high chip select (csN) aborts an unfinished byte without storing it and holds both output enables low.
- R6: Input bits are taken on rising serial clock edges. Output bits change only after falling serial clock edges.
- R7: Location 0x00 bit 7 = 1 drives read data on sdioOut with sdioOe. When the bit is 0, read data goes on sdoOut with sdoOe. Changes to bits 7 and 6 apply from the next chip-select cycle.
- R8: While location 0x00 bit 5 is 1, every other location is held at its reset value and writes to it are dropped. Location 0x00 keeps its written value.
- R9: After reset, locations 0x0B and 0x0F read 0xF9, locations 0x0C and 0x10 read 0x01, and all others read 0x00.
- R10: Only the defined bits are stored. The kept-bit masks are 0x00:E0, 0x02:D0, 0x03:BF, 0x0A:0F, 0x0B:FF, 0x0C:03, 0x0D:FF, 0x0E:C3, 0x0F:FF, 0x10:03, 0x11:FF, 0x12:C3. Any other address drops writes and reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every serial input is sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock |
| sdioIn | input | 1 | Serial data into the block |
| sdioOut | output | 1 | Read data for the shared-line mode |
| sdioOe | output | 1 | Drive enable for the shared line |
| sdoOut | output | 1 | Read data for the separate-pin mode |
| sdoOe | output | 1 | Drive enable for the separate output pin |
| cfgFlat | output | 256 | All locations; location a sits at bits a*8+7 : a*8 |

## Verification
The assertions assume that csN, sclk and sdioIn are synchronous to clk. They also assume that each serial clock level is held for at least one clk cycle, so every edge is seen exactly once. They further assume that the host changes mode or soft-reset bits only when csN is low, so the register bank stays still after two idle cycles. The bench changes every serial input on the falling clk edge and holds each serial clock phase for two clk cycles. It also flips the data input halfway through the high phase, which checks that only the rising edge samples it.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 8;
  localparam int LEN_W    = 2;
  localparam int NUM_REGS = 1 << ADDR_W;
  localparam int CNT_W    = $clog2(DATA_W);
  localparam int RW_BIT   = DATA_W - 1;
  localparam int LEN_LO   = ADDR_W;
  localparam int BIT_3W   = 7;
  localparam int BIT_LSB  = 6;
  localparam int BIT_SRST = 5;

  typedef enum logic [1:0] {PH_INSTR, PH_DATA, PH_DONE} phase_e;

  typedef struct packed {
    logic              wrEn;
    logic              loadRd;
    logic              shiftRd;
    logic              lsbCyc;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } ctrl_strobe_t;

  function automatic logic [DATA_W-1:0] regMask(input int a);
    case (a)
      'h00: return 8'hE0;
      'h02: return 8'hD0;
      'h03: return 8'hBF;
      'h0A: return 8'h0F;
      'h0B, 'h0D, 'h0F, 'h11: return 8'hFF;
      'h0C, 'h10: return 8'h03;
      'h0E, 'h12: return 8'hC3;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] regDefault(input int a);
    case (a)
      'h0B, 'h0F: return 8'hF9;
      'h0C, 'h10: return 8'h01;
      default:    return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/spi_cfg_ctrl.sv
module spi_cfg_ctrl
  import spi_cfg_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  logic         sclk,
  input  logic         sdioIn,
  input  logic         lsbCfg,
  input  logic         threeCfg,
  output ctrl_strobe_t strb,
  output logic         sdoOe,
  output logic         sdioOe
);
  logic              sclkQ;
  phase_e            phase;
  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] inShift;
  logic [DATA_W-1:0] byteNext;
  logic              rwQ;
  logic [LEN_W-1:0]  bytesLeft;
  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] stepAddr;
  logic              lsbCyc;
  logic              threeCyc;
  logic              sclkRise;
  logic              sclkFall;
  logic              lastBit;
  logic              readOe;

  assign sclkRise = sclk & ~sclkQ & ~csN;
  assign sclkFall = ~sclk & sclkQ & ~csN;
  assign lastBit  = (bitCnt == CNT_W'(DATA_W - 1));
  assign byteNext = lsbCyc ? {sdioIn, inShift[DATA_W-1:1]}
                           : {inShift[DATA_W-2:0], sdioIn};
  assign stepAddr = lsbCyc ? addrQ + 1'b1 : addrQ - 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkQ <= 1'b0;
    else       sclkQ <= sclk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_INSTR;
      bitCnt    <= '0;
      inShift   <= '0;
      rwQ       <= 1'b0;
      bytesLeft <= '0;
      addrQ     <= '0;
      lsbCyc    <= 1'b0;
      threeCyc  <= 1'b0;
    end else if (csN) begin
      phase    <= PH_INSTR;
      bitCnt   <= '0;
      lsbCyc   <= lsbCfg;
      threeCyc <= threeCfg;
    end else if (sclkRise && phase != PH_DONE) begin
      inShift <= byteNext;
      bitCnt  <= bitCnt + 1'b1;
      if (lastBit) begin
        if (phase == PH_INSTR) begin
          rwQ       <= byteNext[RW_BIT];
          bytesLeft <= byteNext[LEN_LO +: LEN_W];
          addrQ     <= byteNext[ADDR_W-1:0];
          phase     <= PH_DATA;
        end else begin
          addrQ <= stepAddr;
          if (bytesLeft == '0) phase <= PH_DONE;
          else                 bytesLeft <= bytesLeft - 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb.wrEn    = sclkRise && lastBit && phase == PH_DATA && !rwQ;
    strb.loadRd  = sclkRise && lastBit &&
                   ((phase == PH_INSTR && byteNext[RW_BIT]) ||
                    (phase == PH_DATA && rwQ && bytesLeft != '0));
    strb.shiftRd = sclkFall && phase == PH_DATA && rwQ;
    strb.lsbCyc  = lsbCyc;
    strb.addr    = (phase == PH_INSTR) ? byteNext[ADDR_W-1:0]
                                       : (rwQ ? stepAddr : addrQ);
    strb.data    = byteNext;
  end

  assign readOe = !csN && phase == PH_DATA && rwQ;
  assign sdoOe  = readOe && !threeCyc;
  assign sdioOe = readOe && threeCyc;
endmodule

// File: rtl/spi_cfg_datapath.sv
module spi_cfg_datapath
  import spi_cfg_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrl_strobe_t                 strb,
  output logic                         lsbCfg,
  output logic                         threeCfg,
  output logic [NUM_REGS*DATA_W-1:0]   cfgFlat,
  output logic                         outBit
);
  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [DATA_W-1:0] outShift;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [DATA_W-1:0] MASK = regMask(g);
    localparam logic [DATA_W-1:0] DFLT = regDefault(g);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regs[g] <= DFLT;
      else if (g != 0 && regs[0][BIT_SRST])
        regs[g] <= DFLT;
      else if (strb.wrEn && strb.addr == ADDR_W'(g))
        regs[g] <= strb.data & MASK;
    end
    assign cfgFlat[g*DATA_W +: DATA_W] = regs[g];
  end

  assign lsbCfg   = regs[0][BIT_LSB];
  assign threeCfg = regs[0][BIT_3W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outShift <= '0;
      outBit   <= 1'b0;
    end else if (strb.loadRd) begin
      outShift <= regs[strb.addr];
    end else if (strb.shiftRd) begin
      outBit   <= strb.lsbCyc ? outShift[0] : outShift[DATA_W-1];
      outShift <= strb.lsbCyc ? (outShift >> 1) : (outShift << 1);
    end
  end
endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
  import spi_cfg_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       csN,
  input  logic                       sclk,
  input  logic                       sdioIn,
  output logic                       sdioOut,
  output logic                       sdioOe,
  output logic                       sdoOut,
  output logic                       sdoOe,
  output logic [NUM_REGS*DATA_W-1:0] cfgFlat
);
  ctrl_strobe_t strb;
  logic lsbCfg;
  logic threeCfg;
  logic outBit;

  spi_cfg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdioIn(sdioIn),
    .lsbCfg(lsbCfg), .threeCfg(threeCfg), .strb(strb),
    .sdoOe(sdoOe), .sdioOe(sdioOe)
  );

  spi_cfg_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .lsbCfg(lsbCfg),
    .threeCfg(threeCfg), .cfgFlat(cfgFlat), .outBit(outBit)
  );

  assign sdioOut = outBit;
  assign sdoOut  = outBit;
endmodule

// File: rtl/spi_cfg_slave_chk.sv
module spi_cfg_slave_chk
  import spi_cfg_pkg::*;
(
  input logic                       clk,
  input logic                       rstN,
  input logic                       csN,
  input logic                       sclk,
  input logic                       sdoOe,
  input logic                       sdioOe,
  input logic                       sdoOut,
  input logic [NUM_REGS*DATA_W-1:0] cfgFlat
);
  // R5: deselected port never drives either line
  p_idle_hiz_r5: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (!sdoOe && !sdioOe));

  // R7: at most one of the two output lines is enabled
  p_one_line_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sdoOe, sdioOe}));

  // R6: read data moves only after a falling serial clock
  p_drive_on_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdoOut) |-> ($past(sclk, 2) && !$past(sclk)));

  // R8: soft reset forces gain locations to reset values next cycle
  p_soft_reset_r8: assert property (@(posedge clk) disable iff (!rstN)
    cfgFlat[BIT_SRST] |=> (cfgFlat[8'h0B*DATA_W +: DATA_W] == 8'hF9 &&
                           cfgFlat[8'h0C*DATA_W +: DATA_W] == 8'h01));

  // R5: no location changes while the port has been deselected for a while
  p_quiet_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(csN) && $past(csN, 2)) |-> $stable(cfgFlat));
endmodule

bind spi_cfg_slave spi_cfg_slave_chk u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdoOe(sdoOe),
  .sdioOe(sdioOe), .sdoOut(sdoOut), .cfgFlat(cfgFlat)
);

// File: tb/spi_cfg_slave_tb.sv
`timescale 1ns/1ps
module spi_cfg_slave_tb;
  logic clk = 1'b0;
  logic rstN, csN, sclk, sdioIn;
  logic sdioOut, sdioOe, sdoOut, sdoOe;
  logic [255:0] cfgFlat;

  always #2.5 clk = ~clk;

  spi_cfg_slave u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdioIn(sdioIn),
    .sdioOut(sdioOut), .sdioOe(sdioOe), .sdoOut(sdoOut), .sdoOe(sdoOe),
    .cfgFlat(cfgFlat)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] refRegs [32];
  logic [7:0] txB [4];
  logic [7:0] rxB [4];
  logic [7:0] expB [4];
  bit cycLsb, cycThree;
  bit oeOk, holdOk;

  function automatic logic [7:0] keepBits(input int a);
    logic [7:0] m;
    m = 8'h00;
    if (a == 11 || a == 13 || a == 15 || a == 17) m = 8'hFF;
    if (a == 12 || a == 16) m = 8'h03;
    if (a == 14 || a == 18) m = 8'hC3;
    if (a == 10) m = 8'h0F;
    if (a == 3)  m = 8'hBF;
    if (a == 2)  m = 8'hD0;
    if (a == 0)  m = 8'hE0;
    return m;
  endfunction

  function automatic logic [7:0] resetVal(input int a);
    if (a == 11 || a == 15) return 8'hF9;
    if (a == 12 || a == 16) return 8'h01;
    return 8'h00;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compareAll(input string req);
    for (int a = 0; a < 32; a++)
      check(cfgFlat[a*8 +: 8] === refRegs[a], req, cfgFlat[a*8 +: 8], refRegs[a]);
  endtask

  task automatic refWrite(input int a, input logic [7:0] d);
    if (a == 0) refRegs[0] = d & 8'hE0;
    else if (!refRegs[0][5]) refRegs[a] = d & keepBits(a);
    if (refRegs[0][5])
      for (int j = 1; j < 32; j++) refRegs[j] = resetVal(j);
  endtask

  task automatic startCyc();
    cycLsb = refRegs[0][6];
    cycThree = refRegs[0][7];
    csN = 1'b0;
    tick(2);
  endtask

  task automatic endCyc();
    sclk = 1'b0;
    tick(2);
    csN = 1'b1;
    tick(2);
  endtask

  // one serial bit: fall, sample output, rise, flip data mid-high (R6)
  task automatic bitOut(input logic b, output logic rb);
    logic again;
    sclk = 1'b0;
    sdioIn = b;
    tick(2);
    rb = cycThree ? sdioOut : sdoOut;
    oeOk = cycThree ? (sdioOe && !sdoOe) : (sdoOe && !sdioOe);
    sclk = 1'b1;
    tick(1);
    sdioIn = ~b;
    tick(1);
    again = cycThree ? sdioOut : sdoOut;
    if (again !== rb) holdOk = 1'b0;
  endtask

  task automatic byteXfer(input logic [7:0] v, output logic [7:0] r);
    logic rb;
    for (int i = 0; i < 8; i++) begin
      int idx;
      idx = cycLsb ? i : 7 - i;
      bitOut(v[idx], rb);
      r[idx] = rb;
    end
  endtask

  task automatic sendCmdBody(input bit rw, input int nb, input logic [4:0] a);
    logic [7:0] dummy;
    logic [4:0] ad;
    byteXfer({rw, 2'(nb - 1), a}, dummy);
    ad = a;
    for (int k = 0; k < nb; k++) begin
      expB[k] = refRegs[ad];
      holdOk = 1'b1;
      byteXfer(txB[k], rxB[k]);
      if (rw) begin
        check(oeOk, "R7 line select", {sdoOe, sdioOe}, {cycThree ? 2'b01 : 2'b10});
        check(holdOk, "R6 output held while clock high", 0, 0);
      end else refWrite(ad, txB[k]);
      ad = cycLsb ? ad + 1'b1 : ad - 1'b1;
    end
  endtask

  task automatic xfer(input bit rw, input int nb, input logic [4:0] a);
    startCyc();
    sendCmdBody(rw, nb, a);
    endCyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] junk;
    logic rb;
    rstN = 1'b0; csN = 1'b1; sclk = 1'b0; sdioIn = 1'b0;
    for (int j = 0; j < 32; j++) refRegs[j] = resetVal(j);
    tick(4);
    rstN = 1'b1;
    tick(2);

    // R5: idle outputs off; R9: defaults
    check(!sdoOe && !sdioOe, "R5 idle enables", {sdoOe, sdioOe}, 0);
    compareAll("R9 reset values");

    // R1/R10: single-byte write sweep, MSB-first
    for (int a = 1; a < 32; a++) begin
      txB[0] = 8'((a * 53 + 17) & 255);
      xfer(1'b0, 1, 5'(a));
    end
    compareAll("R10 masked write sweep");
    for (int a = 0; a < 32; a++) begin
      xfer(1'b1, 1, 5'(a));
      check(rxB[0] === expB[0], "R1 read sweep", rxB[0], expB[0]);
    end

    // R3: four-byte MSB-first write steps down from 0x12
    txB[0] = 8'h11; txB[1] = 8'h22; txB[2] = 8'h33; txB[3] = 8'h44;
    xfer(1'b0, 4, 5'h12);
    compareAll("R3 descending write");
    xfer(1'b1, 4, 5'h0E);
    for (int k = 0; k < 4; k++)
      check(rxB[k] === expB[k], "R3 descending read", rxB[k], expB[k]);

    // R4: extra byte after a one-byte transfer is ignored
    txB[0] = 8'hA5;
    startCyc();
    sendCmdBody(1'b0, 1, 5'h0D);
    byteXfer(8'h3C, junk);
    endCyc();
    compareAll("R4 length limit");

    // R5: abort inside the data byte and inside the command
    startCyc();
    byteXfer({1'b0, 2'b00, 5'h0D}, junk);
    for (int i = 0; i < 4; i++) bitOut(1'b1, rb);
    csN = 1'b1;
    tick(3);
    check(!sdoOe && !sdioOe, "R5 enables after abort", {sdoOe, sdioOe}, 0);
    compareAll("R5 aborted byte dropped");
    startCyc();
    for (int i = 0; i < 5; i++) bitOut(1'b0, rb);
    csN = 1'b1;
    tick(3);
    txB[0] = 8'h5E;
    xfer(1'b0, 1, 5'h0D);
    compareAll("R5 recovery after abort");

    // R2: switch to LSB-first, ascending write
    txB[0] = 8'h40;
    xfer(1'b0, 1, 5'h00);
    txB[0] = 8'h81; txB[1] = 8'hFE; txB[2] = 8'h6C;
    xfer(1'b0, 3, 5'h0B);
    compareAll("R2 LSB-first ascending write");
    // R3: wrap 0x1F -> 0x00 while reading
    xfer(1'b1, 2, 5'h1F);
    check(rxB[0] === 8'h00, "R3 wrap first byte", rxB[0], 8'h00);
    check(rxB[1] === 8'h40, "R3 wrap second byte", rxB[1], 8'h40);

    // R7: back to MSB-first mid-cycle; rest of cycle stays LSB-first
    txB[0] = 8'h00; txB[1] = 8'h77; txB[2] = 8'h90;
    xfer(1'b0, 3, 5'h00);
    compareAll("R7 mode change waits for next cycle");

    // R7: three-wire read
    txB[0] = 8'h80;
    xfer(1'b0, 1, 5'h00);
    xfer(1'b1, 2, 5'h0C);
    check(rxB[0] === expB[0], "R7 shared-line read 0", rxB[0], expB[0]);
    check(rxB[1] === expB[1], "R7 shared-line read 1", rxB[1], expB[1]);

    // R8: soft reset holds defaults, drops writes, then releases
    txB[0] = 8'hA0;
    xfer(1'b0, 1, 5'h00);
    compareAll("R8 soft reset defaults");
    txB[0] = 8'h77;
    xfer(1'b0, 1, 5'h0D);
    compareAll("R8 write dropped in soft reset");
    txB[0] = 8'h00;
    xfer(1'b0, 1, 5'h00);
    txB[0] = 8'h77;
    xfer(1'b0, 1, 5'h0D);
    compareAll("R8 release");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule